// File: doc/BRIEF.md
# Mode Register Unlock Sequence Detector

This block sits beside a pseudo-static memory array. It watches the bus cycles the array receives and picks out a four-cycle unlock-and-program ritual aimed at the top word address. A bus cycle is one window in which chip select is held low. The window is classified as a read or a write, and it is judged at the clock on which chip select returns high. Ordinary traffic is only observed.

When the ritual completes, a small mode register takes the partial-refresh density and the page-length bit from the data of the last write. Any deviation from the ritual aborts it, raises a one-cycle failure pulse and leaves the register as it was. A valid flag tells the rest of the chip whether the register has ever been programmed since reset, because its contents mean nothing before that.

The ritual is always the same four closed cycles, each on the top address: a read, then a read, then a write of an all-zero key word, then a write of the mode word. A new attempt is accepted only after reset or after a cycle that addressed some other location.

Top module: `mrdet_top`

## Requirements
- R1: After reset, `modeValid` and `failPulse` are low.
- R2: A bus cycle is a window with `csN` low that closes when `csN` is sampled high. The window is a read if `oeN` was sampled low in it and `weN` never was. It is a write if `weN` was sampled low in it and `oeN` never was. The address and data taken are the last values sampled while `csN` was low.
- R3: A completed sequence loads `modeDensity` from data bits 1:0 and `modePage` from data bit 2, and raises `modeValid`. The density codes are 00 = largest region, 01 = half, 10 = quarter and 11 = nothing retained. The outputs change on the clock edge that samples `csN` high at the close of the fourth cycle.
- R4: The fourth cycle's data must be 0x0004 to 0x0007, meaning bit 2 is 1 and bits 15:3 are 0. Any other value raises `failPulse` and leaves the register and `modeValid` unchanged.
- R5: The third cycle must be a write of 0x0000 to address 0x3FFFFF. Otherwise the attempt fails.
- R6: A sequence read counts only if `oeN` was high when the window opened and went low inside it. A read with `oeN` held low from the start fails an attempt that is in progress.
- R7: A third consecutive read of 0x3FFFFF, in place of the key write, aborts the attempt with `failPulse`.
- R8: An attempt starts only if the previous closed cycle addressed a location other than 0x3FFFFF, or if no cycle has closed since reset. An unarmed read of the top address starts nothing and raises no failure.
- R9: In an attempt that is in progress, a wrong address, a wrong cycle type or a wrong order raises `failPulse` for exactly one cycle. The detector then returns to idle and the register is untouched.
- R10: The register holds its value across any traffic until the next successful program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 22 | Word address |
| data | input | 16 | Write data seen on the bus |
| modeDensity | output | 2 | Programmed refresh density code |
| modePage | output | 1 | Programmed page-length bit |
| modeValid | output | 1 | Register has been programmed since reset |
| failPulse | output | 1 | One-cycle pulse on an aborted attempt |

## Verification
The hardest state to reach is the one after an abort on a top-address cycle. There the detector is disarmed, so a textbook-correct sequence must be ignored with no failure pulse. The bench reaches it in two ways: it issues a third back-to-back top read, and it tries to reprogram straight after a successful program. It then shows that an access to another address re-arms the detector. A second hard corner is the read whose output enable is held low across the window. The bench drives that shape explicitly in the middle of an attempt. Final-word values are swept over every value 0 to 15 plus several with high bits set.

// File: rtl/mrdet_pkg.sv
package mrdet_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ1 = 2'd1,
    ST_READ2 = 2'd2,
    ST_KEY   = 2'd3
  } seqState_t;

  // summary of one closed bus window, built by the datapath
  typedef struct packed {
    logic close;
    logic isRead;
    logic readToggled;
    logic isWrite;
    logic topAddr;
    logic keyData;
    logic modeOk;
  } busEvent_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMode;
    logic raiseFail;
  } ctrlStrobe_t;
endpackage

// File: rtl/mrdet_datapath.sv
module mrdet_datapath
  import mrdet_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int DENS_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  ctrlStrobe_t       strobe,
  output busEvent_t         evt,
  output logic [DENS_W-1:0] modeDensity,
  output logic              modePage,
  output logic              modeValid,
  output logic              failPulse
);
  localparam int PAGE_BIT = DENS_W;
  localparam int HIGH_LO  = PAGE_BIT + 1;

  logic              csQ;
  logic              startOeHigh;
  logic              sawOe;
  logic              sawWe;
  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataHold;

  // window tracking: opening edge resets the accumulators
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ         <= 1'b1;
      startOeHigh <= 1'b0;
      sawOe       <= 1'b0;
      sawWe       <= 1'b0;
      addrHold    <= '0;
      dataHold    <= '0;
    end else begin
      csQ <= csN;
      if (!csN) begin
        addrHold <= addr;
        dataHold <= data;
        if (csQ) begin
          startOeHigh <= oeN;
          sawOe       <= !oeN;
          sawWe       <= !weN;
        end else begin
          if (!oeN) sawOe <= 1'b1;
          if (!weN) sawWe <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    evt.close       = !csQ && csN;
    evt.isRead      = sawOe && !sawWe;
    evt.readToggled = sawOe && !sawWe && startOeHigh;
    evt.isWrite     = sawWe && !sawOe;
    evt.topAddr     = &addrHold;
    evt.keyData     = (dataHold == '0);
    evt.modeOk      = dataHold[PAGE_BIT] && (dataHold[DATA_W-1:HIGH_LO] == '0);
  end

  // mode register and failure pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeDensity <= '0;
      modePage    <= 1'b0;
      modeValid   <= 1'b0;
      failPulse   <= 1'b0;
    end else begin
      failPulse <= strobe.raiseFail;
      if (strobe.loadMode) begin
        modeDensity <= dataHold[DENS_W-1:0];
        modePage    <= dataHold[PAGE_BIT];
        modeValid   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mrdet_ctrl.sv
module mrdet_ctrl
  import mrdet_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvent_t   evt,
  output ctrlStrobe_t strobe
);
  seqState_t state, stateNext;
  logic      armed;
  logic      topRead;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    topRead   = evt.readToggled && evt.topAddr;
    if (evt.close) begin
      unique case (state)
        ST_IDLE: begin
          if (topRead && armed) stateNext = ST_READ1;
        end
        ST_READ1: begin
          if (topRead) stateNext = ST_READ2;
          else begin
            stateNext        = ST_IDLE;
            strobe.raiseFail = 1'b1;
          end
        end
        ST_READ2: begin
          if (evt.isWrite && evt.topAddr && evt.keyData) stateNext = ST_KEY;
          else begin
            stateNext        = ST_IDLE;
            strobe.raiseFail = 1'b1;
          end
        end
        ST_KEY: begin
          stateNext = ST_IDLE;
          if (evt.isWrite && evt.topAddr && evt.modeOk) strobe.loadMode = 1'b1;
          else strobe.raiseFail = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      armed <= 1'b1;
    end else begin
      state <= stateNext;
      if (evt.close) armed <= !evt.topAddr;
    end
  end
endmodule

// File: rtl/mrdet_top.sv
module mrdet_top
  import mrdet_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int DENS_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [DENS_W-1:0] modeDensity,
  output logic              modePage,
  output logic              modeValid,
  output logic              failPulse
);
  busEvent_t   evt;
  ctrlStrobe_t strobe;

  mrdet_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DENS_W(DENS_W)) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN),
    .addr(addr), .data(data), .strobe(strobe), .evt(evt),
    .modeDensity(modeDensity), .modePage(modePage),
    .modeValid(modeValid), .failPulse(failPulse)
  );

  mrdet_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .strobe(strobe)
  );
endmodule

// File: rtl/mrdet_checker.sv
module mrdet_checker #(
  parameter int DENS_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic [DENS_W-1:0] modeDensity,
  input logic              modePage,
  input logic              modeValid,
  input logic              failPulse
);
  logic csSeen;
  logic closing;

  always_ff @(posedge clk) begin
    if (!rstN) csSeen <= 1'b1;
    else       csSeen <= csN;
  end
  assign closing = !csSeen && csN;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> (!modeValid && !failPulse)); // R1
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN) modeValid |=> modeValid); // R10
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN) !closing |=> $stable({modeDensity, modePage})); // R10
  AST_PAGE_SET: assert property (@(posedge clk) disable iff (!rstN) modeValid |-> modePage); // R4
  AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rstN) failPulse |=> !failPulse); // R9
  AST_FAIL_AT_CLOSE: assert property (@(posedge clk) disable iff (!rstN) failPulse |-> $past(closing)); // R9
  AST_VALID_AT_CLOSE: assert property (@(posedge clk) disable iff (!rstN) $rose(modeValid) |-> $past(closing)); // R3
endmodule

bind mrdet_top mrdet_checker #(.DENS_W(DENS_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .modeDensity(modeDensity),
  .modePage(modePage), .modeValid(modeValid), .failPulse(failPulse)
);

// File: tb/mrdet_top_bench.sv
module mrdet_top_bench;
  localparam logic [21:0] TOP = 22'h3FFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [21:0] addr = '0;
  logic [15:0] data = '0;
  logic [1:0]  modeDensity;
  logic        modePage, modeValid, failPulse;

  int total = 0;
  int bad = 0;
  logic [1:0] expDens = 2'b00;
  logic       expValid = 1'b0;

  always #4 clk = ~clk;

  mrdet_top u_mrdet_top (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN),
    .addr(addr), .data(data), .modeDensity(modeDensity),
    .modePage(modePage), .modeValid(modeValid), .failPulse(failPulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one chip-select window; outputs sampled one edge after the close
  task automatic busCycle(input bit isWr, input logic [21:0] a, input logic [15:0] d,
                          input bit oeHeld);
    @(negedge clk);
    csN = 1'b0; addr = a; data = d; weN = 1'b1; oeN = oeHeld ? 1'b0 : 1'b1;
    @(negedge clk);
    if (isWr) weN = 1'b0; else oeN = 1'b0;
    @(negedge clk);
    csN = 1'b1; weN = 1'b1; oeN = oeHeld ? 1'b0 : 1'b1;
    @(negedge clk);
  endtask

  task automatic expectFail(input bit f, input string tag);
    check(failPulse == f, tag, failPulse, f);
  endtask

  task automatic expectReg(input string tag);
    check(modeValid == expValid, {tag, " valid"}, modeValid, expValid);
    if (expValid) begin
      check(modeDensity == expDens, {tag, " density"}, modeDensity, expDens);
      check(modePage == 1'b1, {tag, " page"}, modePage, 1);
    end
  endtask

  task automatic armCycle();
    busCycle(1'b0, 22'h000123, 16'h0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(modeValid == 1'b0, "R1 valid after reset", modeValid, 0);
    check(failPulse == 1'b0, "R1 fail after reset", failPulse, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 sweep of final data words, starting unprogrammed
    for (int v = 0; v < 19; v++) begin
      logic [15:0] w;
      bit ok;
      w = (v < 16) ? 16'(v) : (v == 16 ? 16'h0104 : (v == 17 ? 16'h8005 : 16'h0014));
      ok = (w >= 16'd4) && (w <= 16'd7);
      armCycle();
      busCycle(1'b0, TOP, 16'h0, 1'b0); expectFail(1'b0, "R2 first read");
      busCycle(1'b0, TOP, 16'h0, 1'b0); expectFail(1'b0, "R2 second read");
      busCycle(1'b1, TOP, 16'h0, 1'b0); expectFail(1'b0, "R5 key write");
      busCycle(1'b1, TOP, w, 1'b0);
      expectFail(!ok, "R4 final word fail");
      if (ok) begin expValid = 1'b1; expDens = w[1:0]; end
      expectReg("R3 R4 register after final word");
    end

    // R3: each density code once more, explicitly
    for (int dn = 3; dn >= 0; dn--) begin
      armCycle();
      busCycle(1'b0, TOP, 16'h0, 1'b0);
      busCycle(1'b0, TOP, 16'h0, 1'b0);
      busCycle(1'b1, TOP, 16'h0, 1'b0);
      busCycle(1'b1, TOP, 16'h0004 | 16'(dn), 1'b0);
      expectFail(1'b0, "R3 program");
      expValid = 1'b1; expDens = 2'(dn);
      expectReg("R3 density code");
    end
    // expDens is now 0

    // R8: retry right after a success is not armed; no fail, no change
    busCycle(1'b0, TOP, 16'h0, 1'b0); expectFail(1'b0, "R8 unarmed read 1");
    busCycle(1'b0, TOP, 16'h0, 1'b0); expectFail(1'b0, "R8 unarmed read 2");
    busCycle(1'b1, TOP, 16'h0, 1'b0); expectFail(1'b0, "R8 unarmed key");
    busCycle(1'b1, TOP, 16'h0006, 1'b0); expectFail(1'b0, "R8 unarmed final");
    expectReg("R8 register unchanged");

    // R7: three top reads abort, then the rest is ignored
    armCycle();
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b0, TOP, 16'h0, 1'b0); expectFail(1'b1, "R7 third top read");
    busCycle(1'b1, TOP, 16'h0, 1'b0); expectFail(1'b0, "R7 disarmed key");
    busCycle(1'b1, TOP, 16'h0005, 1'b0); expectFail(1'b0, "R7 disarmed final");
    expectReg("R7 register unchanged");

    // R6: second read with output enable held low
    armCycle();
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b0, TOP, 16'h0, 1'b1); expectFail(1'b1, "R6 held oe read");
    oeN = 1'b1;
    expectReg("R6 register unchanged");

    // R9: wrong order, key write arrives after only one read
    armCycle();
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b1, TOP, 16'h0, 1'b0); expectFail(1'b1, "R9 wrong order");
    @(negedge clk);
    check(failPulse == 1'b0, "R9 pulse one cycle", failPulse, 0);

    // R9: wrong address on the second read
    armCycle();
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b0, TOP - 22'd1, 16'h0, 1'b0); expectFail(1'b1, "R9 wrong address");

    // R5: bad key word
    armCycle();
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b1, TOP, 16'h0001, 1'b0); expectFail(1'b1, "R5 bad key");
    busCycle(1'b1, TOP, 16'h0007, 1'b0); expectFail(1'b0, "R5 no follow-on");
    expectReg("R5 register unchanged");

    // R10: unrelated traffic leaves the register alone
    for (int k = 0; k < 8; k++) begin
      busCycle(k[0], 22'(k * 4099), 16'(k * 77 + 4), 1'b0);
      expectFail(1'b0, "R10 plain traffic");
    end
    expectReg("R10 register retained");

    // R2: a window with neither strobe breaks an attempt
    armCycle();
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    @(negedge clk); csN = 1'b0; addr = TOP;
    @(negedge clk); csN = 1'b1;
    @(negedge clk); expectFail(1'b1, "R2 idle window in attempt");

    // final good program after all aborts
    armCycle();
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b0, TOP, 16'h0, 1'b0);
    busCycle(1'b1, TOP, 16'h0, 1'b0);
    busCycle(1'b1, TOP, 16'h0006, 1'b0);
    expDens = 2'b10;
    expectFail(1'b0, "R3 final program");
    expectReg("R3 final program");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule